// File: doc/BRIEF.md
# Overlapped Translation and Cache Load Controller

This block serves CPU loads from a physically tagged cache. The cache is read in parallel with the page-number lookup, so a hit costs one cycle. Once a load is accepted, the set is chosen from virtual address bits that lie inside the page displacement. Translation never changes those bits, so the set and word can be read before the physical page number is known. In that same cycle the upper virtual bits go to an external TLB. The physical page number it returns is compared against the tags of every way in the selected set.

There are three outcomes. If the TLB hits and a way's tag matches, the word is returned to the CPU. If the TLB hits but no way matches, the controller starts a four-beat line read from memory at the translated address. It fills a victim way chosen by a per-set round-robin pointer, then replays the lookup. If the TLB misses, the controller asks a translation unit for the page number. When the answer arrives, it replays the lookup through the same hit/fetch decision, using that page number.

The cache size is one page times the number of ways. The set index therefore always fits inside the page offset, and growing the cache means adding ways. With the default parameters that gives 4 KB, 1 KB pages, four ways, 64 sets and 16-byte lines.

Top module: `ovl_load_ctrl`

## Requirements
- R1: After reset, `ld_ready` is 1 and `ld_done`, `mem_req` and `xlate_req` are 0. Every cache line is invalid, so the first load to any address fetches from memory.
- R2: The set is virtual address bits [9:4] and the word within the line is bits [3:2]. `tlb_vpn` carries bits [31:10] during the lookup cycle. All four words of a filled line return their own memory contents.
- R3: When the TLB hits and a valid way in the set holds a tag equal to the returned page number, `ld_done` is 1 with the word on `ld_data` in the first cycle after the load is accepted. No memory or translation request is made.
- R4: When the TLB hits but no way matches, `mem_req` is 1 for one cycle with `mem_addr` = {page number, VA[9:4], 4'b0}, and `ld_done` stays 0 in that cycle.
- R5: A refill takes four `mem_rvalid` beats carrying words 0 to 3 in order. The lookup is then replayed and delivers the requested word from the new line.
- R6: Each set keeps its own round-robin victim pointer, starting at way 0 and advancing once per refill. After four refills of distinct pages in one set all four lines hit. A fifth refill evicts the line filled first.
- R7: A valid line in the same set whose tag is a different page number does not hit. A load whose VA differs only in page number from a resident line fetches from memory.
- R8: When the TLB misses, `xlate_req` is 1 for one cycle with `xlate_vpn` = VA[31:10], no memory request is made, and the controller waits for `xlate_done`.
- R9: After `xlate_done`, the lookup is replayed with `xlate_ppn` as the page number. A matching line is delivered without a memory read; otherwise a refill at that page number follows.
- R10: While `ld_ready` is 0, `ld_req` and `ld_vaddr` are ignored. The load in progress completes with the address captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | CPU load request |
| ld_vaddr | input | VA_W | Load virtual byte address |
| ld_ready | output | 1 | Controller idle, accepts a load |
| ld_done | output | 1 | Load data valid this cycle |
| ld_data | output | DATA_W | Loaded word |
| tlb_vpn | output | VPN_W | Virtual page number presented to the TLB |
| tlb_hit | input | 1 | TLB holds a mapping for `tlb_vpn` |
| tlb_ppn | input | PPN_W | Physical page number from the TLB |
| mem_req | output | 1 | Start a line read |
| mem_addr | output | PA_W | Line-aligned physical address |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| xlate_req | output | 1 | Request a full translation |
| xlate_vpn | output | VPN_W | Page number to translate |
| xlate_done | input | 1 | Translation result valid |
| xlate_ppn | input | PPN_W | Translated physical page number |

## Verification
The case that is hardest to reach from the ports is eviction order inside a single set. It only becomes visible after four refills of distinct pages sharing the same index bits, followed by reloads that show which line left. The stimulus uses a TLB model whose mapping rotates the page number, so virtual addresses with identical low ten bits land on distinct physical pages. A run of five pages through one set then exposes which way the pointer picked. A second hard case is the replay after translation landing on an already resident line. To reach it, a load that misses the TLB is issued twice: the first fills the line, and the second must finish with no memory read.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_FILL = 2'd2,
    S_XLAT = 2'd3
  } ovl_state_e;
endpackage

// File: rtl/ovl_victim_rr.sv
module ovl_victim_rr #(
  parameter int SET_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set,
  input  logic             adv,
  output logic [WAY_W-1:0] victim
);
  localparam int SETS = 2 ** SET_W;

  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[set] <= WAY_W'(ptr_q[set] + 1'b1);
    end
  end

  assign victim = ptr_q[set];

  // R6: a refill moves only its own set's pointer by one way
  p_rr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr_q[$past(set)] == WAY_W'($past(ptr_q[set]) + 1'b1));
endmodule

// File: rtl/ovl_tag_store.sv
module ovl_tag_store #(
  parameter int SET_W = 6,
  parameter int WAY_W = 2,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic [2**WAY_W-1:0] way_match,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int SETS = 2 ** SET_W;
  localparam int WAYS = 2 ** WAY_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == cmp_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |way_match;

  // R6/R7: refills never leave two ways of a set holding the same page
  p_match_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));
endmodule

// File: rtl/ovl_data_store.sv
module ovl_data_store #(
  parameter int SET_W  = 6,
  parameter int WAY_W  = 2,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = SET_W + WAY_W + WORD_W;
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_set, wr_way, wr_word}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_set, rd_way, rd_word}];
endmodule

// File: rtl/ovl_load_ctrl.sv
module ovl_load_ctrl
  import ovl_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 10,
  parameter int LINE_W = 4,
  parameter int WAY_W  = 2,
  parameter int DATA_W = 32,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [VA_W-1:0]   ld_vaddr,
  output logic              ld_ready,
  output logic              ld_done,
  output logic [DATA_W-1:0] ld_data,
  output logic [VPN_W-1:0]  tlb_vpn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              xlate_req,
  output logic [VPN_W-1:0]  xlate_vpn,
  input  logic              xlate_done,
  input  logic [PPN_W-1:0]  xlate_ppn
);
  // The set index sits entirely inside the page displacement by construction.
  localparam int SET_W  = PAGE_W - LINE_W;
  localparam int WORD_W = LINE_W - 2;
  localparam int WAYS   = 2 ** WAY_W;

  function automatic logic [SET_W-1:0] f_set(input logic [VA_W-1:0] va);
    return va[PAGE_W-1:LINE_W];
  endfunction

  function automatic logic [WORD_W-1:0] f_word(input logic [VA_W-1:0] va);
    return va[LINE_W-1:2];
  endfunction

  function automatic logic [VPN_W-1:0] f_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_W];
  endfunction

  function automatic logic [PA_W-1:0] f_line_pa(input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0]  va);
    return {ppn, va[PAGE_W-1:LINE_W], {LINE_W{1'b0}}};
  endfunction

  ovl_state_e        state_q;
  logic [VA_W-1:0]   va_q;
  logic              rep_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [WORD_W-1:0] beat_q;

  // named decision events
  logic              look;
  logic              accept;
  logic              eff_hit;
  logic [PPN_W-1:0]  eff_ppn;
  logic              cache_hit;
  logic              deliver;
  logic              go_mem;
  logic              go_xlat;
  logic              fill_beat;
  logic              fill_done;
  logic [WAYS-1:0]   way_match;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic [SET_W-1:0]  cur_set;

  assign cur_set   = f_set(va_q);
  assign look      = (state_q == S_LOOK);
  assign accept    = (state_q == S_IDLE) && ld_req;
  assign eff_hit   = rep_q || tlb_hit;
  assign eff_ppn   = rep_q ? ppn_q : tlb_ppn;
  assign deliver   = look && eff_hit && cache_hit;
  assign go_mem    = look && eff_hit && !cache_hit;
  assign go_xlat   = look && !eff_hit;
  assign fill_beat = (state_q == S_FILL) && mem_rvalid;
  assign fill_done = fill_beat && (&beat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      rep_q   <= 1'b0;
      ppn_q   <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          va_q    <= ld_vaddr;
          rep_q   <= 1'b0;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          if (deliver) begin
            state_q <= S_IDLE;
          end else if (go_mem) begin
            ppn_q   <= eff_ppn;
            rep_q   <= 1'b1;
            beat_q  <= '0;
            state_q <= S_FILL;
          end else begin
            state_q <= S_XLAT;
          end
        end
        S_FILL: if (fill_beat) begin
          beat_q <= WORD_W'(beat_q + 1'b1);
          if (fill_done) state_q <= S_LOOK;
        end
        S_XLAT: if (xlate_done) begin
          ppn_q   <= xlate_ppn;
          rep_q   <= 1'b1;
          state_q <= S_LOOK;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  ovl_tag_store #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(PPN_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (cur_set),
    .cmp_tag   (eff_ppn),
    .way_match (way_match),
    .hit       (cache_hit),
    .hit_way   (hit_way),
    .wr_en     (fill_done),
    .wr_set    (cur_set),
    .wr_way    (victim),
    .wr_tag    (ppn_q)
  );

  ovl_data_store #(.SET_W(SET_W), .WAY_W(WAY_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (fill_beat),
    .wr_set  (cur_set),
    .wr_way  (victim),
    .wr_word (beat_q),
    .wr_data (mem_rdata),
    .rd_set  (cur_set),
    .rd_way  (hit_way),
    .rd_word (f_word(va_q)),
    .rd_data (ld_data)
  );

  ovl_victim_rr #(.SET_W(SET_W), .WAY_W(WAY_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (cur_set),
    .adv    (fill_done),
    .victim (victim)
  );

  assign ld_ready  = (state_q == S_IDLE);
  assign ld_done   = deliver;
  assign tlb_vpn   = f_vpn(va_q);
  assign mem_req   = go_mem;
  assign mem_addr  = f_line_pa(eff_ppn, va_q);
  assign xlate_req = go_xlat;
  assign xlate_vpn = f_vpn(va_q);

  // R3: a delivered load returns the controller to idle
  p_done_then_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ld_ready);

  // R4: a line read is aligned and never coincides with data or translation
  p_memreq_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[LINE_W-1:0] == '0) && !ld_done && !xlate_req);

  // R5: the replay after a completed refill hits the new line
  p_fill_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> ld_done);

  // R8: a translation request is not followed by a memory read before the reply
  p_xlate_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_req |=> !mem_req);

  // R10: the captured address holds while the controller is busy
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |=> va_q == $past(va_q));
endmodule

// File: tb/sim_ovl_load_ctrl.sv
module sim_ovl_load_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0;
  logic [31:0] ld_vaddr = '0;
  logic        ld_ready, ld_done;
  logic [31:0] ld_data;
  logic [21:0] tlb_vpn;
  logic        tlb_hit;
  logic [21:0] tlb_ppn;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xlate_req;
  logic [21:0] xlate_vpn;
  logic        xlate_done = 1'b0;
  logic [21:0] xlate_ppn = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit mem_seen, xl_seen;
  logic [31:0] mem_last;
  logic [21:0] xl_last;

  always #5 clk = ~clk;

  // page mapping: rotation plus xor, one-to-one
  function automatic logic [21:0] tmap(input logic [21:0] v);
    return {v[10:0], v[21:11]} ^ 22'h0F0F0;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // TLB model: pages with bit 21 clear are resident
  assign tlb_hit = ~tlb_vpn[21];
  assign tlb_ppn = tmap(tlb_vpn);

  ovl_load_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_vaddr(ld_vaddr), .ld_ready(ld_ready),
    .ld_done(ld_done), .ld_data(ld_data),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xlate_req(xlate_req), .xlate_vpn(xlate_vpn), .xlate_done(xlate_done), .xlate_ppn(xlate_ppn)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory responder: four beats starting two cycles after the request
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      mem_seen = 1'b1;
      mem_last = mem_addr;
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(mem_last + 32'(4 * b));
        @(negedge clk);
      end
      mem_rvalid = 1'b0;
    end
  end

  // translation responder
  initial forever begin
    @(negedge clk);
    if (xlate_req) begin
      xl_seen = 1'b1;
      xl_last = xlate_vpn;
      @(negedge clk);
      @(negedge clk);
      xlate_done = 1'b1;
      xlate_ppn  = tmap(xl_last);
      @(negedge clk);
      xlate_done = 1'b0;
    end
  end

  task automatic do_load(input logic [31:0] va, input bit exp_mem, input bit exp_xl,
                         input bit hold_busy, input string rq);
    int cyc;
    logic [21:0] ppn;
    logic [31:0] exp_data;
    ppn      = tmap(va[31:10]);
    exp_data = mem_word({ppn, va[9:2], 2'b00});
    @(negedge clk);
    mem_seen = 1'b0;
    xl_seen  = 1'b0;
    check(ld_ready == 1'b1, rq, "ready before load", 32'(ld_ready), 32'd1);
    ld_req   = 1'b1;
    ld_vaddr = va;
    @(negedge clk);
    if (hold_busy) ld_vaddr = ~va;
    else ld_req = 1'b0;
    cyc = 1;
    while (!ld_done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    ld_req = 1'b0;
    check(ld_done == 1'b1, rq, "load completes", 32'(ld_done), 32'd1);
    check(ld_data == exp_data, rq, "load data", ld_data, exp_data);
    check(mem_seen == exp_mem, rq, "memory read made", 32'(mem_seen), 32'(exp_mem));
    check(xl_seen == exp_xl, rq, "translation made", 32'(xl_seen), 32'(exp_xl));
    if (exp_mem)
      check(mem_last == {ppn, va[9:4], 4'b0}, rq, "line address", mem_last, {ppn, va[9:4], 4'b0});
    if (exp_xl)
      check(xl_last == va[31:10], rq, "translation page", 32'(xl_last), 32'(va[31:10]));
    if (!exp_mem && !exp_xl)
      check(cyc == 1, rq, "hit latency", 32'(cyc), 32'd1);
    @(negedge clk);
    check(ld_ready == 1'b1, rq, "idle after load", 32'(ld_ready), 32'd1);
  endtask

  task automatic t_reset_state();
    check(ld_ready == 1'b1, "R1", "ready", 32'(ld_ready), 32'd1);
    check(ld_done == 1'b0, "R1", "done", 32'(ld_done), 32'd0);
    check(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
    check(xlate_req == 1'b0, "R1", "xlate_req", 32'(xlate_req), 32'd0);
    do_load(32'h0000_1404, 1'b1, 1'b0, 1'b0, "R1"); // cold cache fetches
  endtask

  task automatic t_fill_and_words();
    do_load(32'h0000_0C38, 1'b1, 1'b0, 1'b0, "R4");  // R4/R5 refill then replay
    do_load(32'h0000_0C30, 1'b0, 1'b0, 1'b0, "R2");  // word 0
    do_load(32'h0000_0C34, 1'b0, 1'b0, 1'b0, "R2");  // word 1
    do_load(32'h0000_0C3C, 1'b0, 1'b0, 1'b0, "R5");  // word 3 of refilled line
    do_load(32'h0000_0C38, 1'b0, 1'b0, 1'b0, "R3");  // repeat hits in one cycle
  endtask

  task automatic t_alias_tag();
    do_load({22'd6, 10'h100}, 1'b1, 1'b0, 1'b0, "R7");
    do_load({22'd7, 10'h100}, 1'b1, 1'b0, 1'b0, "R7");  // same set, other page
    do_load({22'd6, 10'h100}, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_round_robin();
    for (int p = 1; p <= 4; p++) do_load({22'(p + 32), 10'h2C4}, 1'b1, 1'b0, 1'b0, "R6");
    for (int p = 1; p <= 4; p++) do_load({22'(p + 32), 10'h2C4}, 1'b0, 1'b0, 1'b0, "R6");
    do_load({22'd37, 10'h2C4}, 1'b1, 1'b0, 1'b0, "R6");   // evicts page 33
    do_load({22'd34, 10'h2C4}, 1'b0, 1'b0, 1'b0, "R6");
    do_load({22'd36, 10'h2C4}, 1'b0, 1'b0, 1'b0, "R6");
    do_load({22'd37, 10'h2C4}, 1'b0, 1'b0, 1'b0, "R6");
    do_load({22'd33, 10'h2C4}, 1'b1, 1'b0, 1'b0, "R6");   // evicts page 34
    do_load({22'd35, 10'h2C4}, 1'b0, 1'b0, 1'b0, "R6");
    do_load({22'd34, 10'h2C4}, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_translation();
    do_load({1'b1, 21'h00ABC, 10'h3F8}, 1'b1, 1'b1, 1'b0, "R8");
    do_load({1'b1, 21'h00ABC, 10'h3F4}, 1'b0, 1'b1, 1'b0, "R9"); // replay hits
    do_load({1'b1, 21'h01234, 10'h3F8}, 1'b1, 1'b1, 1'b0, "R9"); // replay misses
  endtask

  task automatic t_busy_ignored();
    do_load({22'd90, 10'h0A8}, 1'b1, 1'b0, 1'b1, "R10");
    do_load({22'd90, 10'h0A8}, 1'b0, 1'b0, 1'b1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fill_and_words();
    t_alias_tag();
    t_round_robin();
    t_translation();
    t_busy_ignored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule